// File: doc/BRIEF.md
# System configuration register file with interrupt-line port selection

This block holds eleven 32-bit configuration registers behind a simple word-addressed read/write bus. Each bit follows one of several access rules: plain read/write, reserved and read as zero, sticky set-only (only a reset clears it), clear-only (only a reset sets it again), or a status flag that a hardware event raises and a write of one lowers. Reads are combinational from the address. A write is captured on the rising clock edge while `bus_wr` is high.

The block also steers sixteen external-interrupt lines. Four of the registers each carry four 4-bit port selectors. Selector k picks which GPIO port drives interrupt line k, and only the pin with the same number as the line is used. GPIO levels arrive as one flat vector indexed port·16 + pin, and the sixteen selected levels leave on `irq_line` with no register in the path.

The block has no state machine. Register state changes only on the clock edge, under synchronous active-low reset. Word index = `bus_addr[7:2]`: 0 remap, 1 config A, 2..5 line selectors for lines 0-3, 4-7, 8-11, 12-15, 6 control/status, 7 config B, 8 protect-low, 9 key, 10 protect-high.

Top module: `sys_cfg_mux`

## Requirements
- R1: After a reset cycle, config A (index 1) reads 0x7C000001 and every other register reads 0x00000000.
- R2: Remap (index 0) stores only bits 0x00000107 and key (index 9) stores only bits [7:0]. All their other bits read as zero and can be written back to zero.
- R3: Config A stores only bits 0xFCFF0101, and the other bits read as zero. Bit 0 is clear-only: once it has been written 0, writing 1 leaves it 0 until reset.
- R4: Each selector register stores only bits [15:0], as four 4-bit fields. Field k (bits [4k+3:4k]) of selector register j drives line 4·j+k, and bits [31:16] read as zero.
- R5: Config B bits [3:0] are set-only. Writing 1 sets a bit, writing 0 has no effect, and only reset clears them.
- R6: Config B bit 8 is set by a high `parity_evt` and cleared by writing 1 to it. Writing 1 while it is 0 leaves it 0, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write wins. Other config B bits read as zero.
- R7: Every bit of protect-low (index 8) and protect-high (index 10) is set-only. Writing 1 sets the bit and it stays set until reset.
- R8: Reads at index 11 and above, or with `bus_addr[1:0]` non-zero, return zero. Writes there change no register.
- R9: `irq_line[k]` equals `gpio_lvl[s·16 + k]`, where s is line k's selector (0 = port A, 1 = port B, up to 7). Levels on other ports or other pins do not reach the line.
- R10: A selector value from 8 to 15 drives its line low.
- R11: Control/status (index 6) always reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, captured at rising edge |
| bus_addr | input | 8 | Byte address, word index in [7:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| parity_evt | input | 1 | Event that raises config B bit 8 |
| gpio_lvl | input | 128 | GPIO levels, index port·16+pin |
| irq_line | output | 16 | Selected interrupt-line levels |

## Verification
A write driven at a falling edge is taken at the next rising edge, so its effect is readable from half a cycle after that edge. The bench reads one full cycle later, after driving the address at the following falling edge. Read data and `irq_line` are combinational, so the bench samples them 1 ns after changing the address or `gpio_lvl`, well before the next edge. Sticky and clear-only bits are checked in three steps: a write that tries to undo the bit, a read back, and a mid-run reset that is expected to restore the reset value.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

    typedef enum logic [3:0] {
        RG_REMAP   = 4'd0,
        RG_CFGA    = 4'd1,
        RG_SEL0    = 4'd2,
        RG_SEL1    = 4'd3,
        RG_SEL2    = 4'd4,
        RG_SEL3    = 4'd5,
        RG_CTLSTAT = 4'd6,
        RG_CFGB    = 4'd7,
        RG_WPLO    = 4'd8,
        RG_KEY     = 4'd9,
        RG_WPHI    = 4'd10
    } reg_idx_e;

    localparam int unsigned NUM_REGS   = 11;
    localparam logic [31:0] REMAP_MASK = 32'h0000_0107;
    localparam logic [31:0] CFGA_MASK  = 32'hFCFF_0101;
    localparam logic [31:0] CFGA_RST   = 32'h7C00_0001;
    localparam logic [31:0] KEY_MASK   = 32'h0000_00FF;
    localparam int unsigned CFGB_LOCK_W = 4;
    localparam int unsigned CFGB_FLAG_BIT = 8;

endpackage

// File: rtl/syscfg_regs.sv
module syscfg_regs
    import syscfg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LINES  = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   parity_evt,
    output logic [LINES*SEL_W-1:0] sel_flat
);

    localparam int unsigned IDX_W     = ADDR_W - 2;
    localparam int unsigned FLD_PER   = 4;
    localparam int unsigned SEL_BITS  = FLD_PER * SEL_W;
    localparam int unsigned NSEL      = LINES / FLD_PER;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             wr_ok;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_wr && aligned;

    // Storage
    logic [DATA_W-1:0]      remap_q;
    logic [DATA_W-1:0]      cfga_q;
    logic [CFGB_LOCK_W-1:0] lock_q;
    logic                   flag_q;
    logic [DATA_W-1:0]      wplo_q;
    logic [DATA_W-1:0]      wphi_q;
    logic [DATA_W-1:0]      key_q;
    logic [SEL_BITS-1:0]    sel_q [NSEL];

    function automatic logic hit(input logic [IDX_W-1:0] i, input int unsigned r);
        return i == IDX_W'(r);
    endfunction

    // Plain and masked registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_q <= '0;
            key_q   <= '0;
        end else if (wr_ok) begin
            if (hit(idx, RG_REMAP)) remap_q <= bus_wdata & REMAP_MASK;
            if (hit(idx, RG_KEY))   key_q   <= bus_wdata & KEY_MASK;
        end
    end

    // Config A: masked, bit 0 clear-only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfga_q <= CFGA_RST;
        end else if (wr_ok && hit(idx, RG_CFGA)) begin
            cfga_q[DATA_W-1:1] <= bus_wdata[DATA_W-1:1] & CFGA_MASK[DATA_W-1:1];
            cfga_q[0]          <= cfga_q[0] & bus_wdata[0];
        end
    end

    // Config B: set-only lock bits and event flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ok && hit(idx, RG_CFGB))
                lock_q <= lock_q | bus_wdata[CFGB_LOCK_W-1:0];
            if (parity_evt)
                flag_q <= 1'b1;
            else if (wr_ok && hit(idx, RG_CFGB) && bus_wdata[CFGB_FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    // Write-protect registers: sticky set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wplo_q <= '0;
            wphi_q <= '0;
        end else if (wr_ok) begin
            if (hit(idx, RG_WPLO)) wplo_q <= wplo_q | bus_wdata;
            if (hit(idx, RG_WPHI)) wphi_q <= wphi_q | bus_wdata;
        end
    end

    // Selector registers
    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_sel
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sel_q[g] <= '0;
                else if (wr_ok && hit(idx, int'(RG_SEL0) + g))
                    sel_q[g] <= bus_wdata[SEL_BITS-1:0];
            end
            assign sel_flat[g*SEL_BITS +: SEL_BITS] = sel_q[g];
        end
    endgenerate

    // Read path
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (hit(idx, RG_REMAP)) bus_rdata = remap_q;
            if (hit(idx, RG_CFGA))  bus_rdata = cfga_q;
            if (hit(idx, RG_CFGB)) begin
                bus_rdata[CFGB_LOCK_W-1:0]  = lock_q;
                bus_rdata[CFGB_FLAG_BIT]    = flag_q;
            end
            if (hit(idx, RG_WPLO))  bus_rdata = wplo_q;
            if (hit(idx, RG_KEY))   bus_rdata = key_q;
            if (hit(idx, RG_WPHI))  bus_rdata = wphi_q;
            for (int s = 0; s < NSEL; s++)
                if (hit(idx, int'(RG_SEL0) + s))
                    bus_rdata[SEL_BITS-1:0] = sel_q[s];
        end
    end

    // Assertions
    AST_CFGA_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfga_q[0] |=> !cfga_q[0]); // R3
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R5
    AST_WP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((wplo_q & $past(wplo_q)) == $past(wplo_q)) &&
                  ((wphi_q & $past(wphi_q)) == $past(wphi_q)))); // R7
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && hit(idx, RG_CFGB) && bus_wdata[CFGB_FLAG_BIT] && !parity_evt) |=> !flag_q); // R6
    AST_FLAG_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        parity_evt |=> flag_q); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!aligned || (idx >= IDX_W'(NUM_REGS))) |-> (bus_rdata == '0)); // R8
    AST_CTLSTAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && hit(idx, RG_CTLSTAT)) |-> (bus_rdata == '0)); // R11
    AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && idx >= IDX_W'(RG_SEL0) && idx <= IDX_W'(RG_SEL3))
            |-> (bus_rdata[DATA_W-1:SEL_BITS] == '0)); // R4

endmodule

// File: rtl/syscfg_line_mux.sv
module syscfg_line_mux #(
    parameter int unsigned PORTS = 8,
    parameter int unsigned PINS  = 16,
    parameter int unsigned SEL_W = 4
) (
    input  logic [PINS*SEL_W-1:0]  sel_flat,
    input  logic [PORTS*PINS-1:0]  gpio_lvl,
    output logic [PINS-1:0]        irq_line
);

    localparam int unsigned PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1;

    generate
        for (genvar k = 0; k < PINS; k++) begin : g_line
            logic [SEL_W-1:0] sel;
            logic [PORTS-1:0] pick;
            logic             in_range;

            assign sel = sel_flat[k*SEL_W +: SEL_W];

            for (genvar p = 0; p < PORTS; p++) begin : g_port
                assign pick[p] = gpio_lvl[p*PINS + k];
            end

            assign in_range    = ({1'b0, sel} < (SEL_W+1)'(PORTS));
            assign irq_line[k] = in_range ? pick[sel[PSEL_W-1:0]] : 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sys_cfg_mux.sv
module sys_cfg_mux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PORTS  = 8,
    parameter int unsigned LINES  = 16,
    parameter int unsigned SEL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic                    parity_evt,
    input  logic [PORTS*LINES-1:0]  gpio_lvl,
    output logic [LINES-1:0]        irq_line
);

    logic [LINES*SEL_W-1:0] sel_flat;

    syscfg_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LINES  (LINES),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .parity_evt (parity_evt),
        .sel_flat   (sel_flat)
    );

    syscfg_line_mux #(
        .PORTS (PORTS),
        .PINS  (LINES),
        .SEL_W (SEL_W)
    ) u_mux (
        .sel_flat (sel_flat),
        .gpio_lvl (gpio_lvl),
        .irq_line (irq_line)
    );

    AST_LINE0_PORTA: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat[SEL_W-1:0] == '0) |-> (irq_line[0] == gpio_lvl[0])); // R9
    AST_LINE0_PORTB: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat[SEL_W-1:0] == SEL_W'(1)) |-> (irq_line[0] == gpio_lvl[LINES])); // R9
    AST_SEL_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sel_flat[SEL_W-1:0]} >= (SEL_W+1)'(PORTS)) |-> !irq_line[0]); // R10

endmodule

// File: tb/sys_cfg_mux_test.sv
module sys_cfg_mux_test;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         parity_evt = 1'b0;
    logic [127:0] gpio_lvl = '0;
    logic [15:0]  irq_line;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] sel_model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_cfg_mux uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .parity_evt (parity_evt),
        .gpio_lvl   (gpio_lvl),
        .irq_line   (irq_line)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'(idx * 4); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = 8'(idx * 4);
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) sel_model[s] = '0;
    endtask

    function automatic logic [15:0] exp_lines(input logic [127:0] g);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) begin
            int s;
            s = int'(sel_model[k/4][(k%4)*4 +: 4]);
            r[k] = (s < 8) ? g[s*16 + k] : 1'b0;
        end
        return r;
    endfunction

    task automatic line_chk(input string req);
        #1;
        chk(req, {16'h0, irq_line}, {16'h0, exp_lines(gpio_lvl)});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset values
        for (int i = 0; i < 11; i++)
            rd_chk("R1", i, (i == 1) ? 32'h7C000001 : 32'h0);

        // R2 masks on remap and key
        wr(0, 32'hFFFFFFFF); rd_chk("R2", 0, 32'h00000107);
        wr(0, 32'h0);        rd_chk("R2", 0, 32'h0);
        wr(9, 32'hFFFFFFFF); rd_chk("R2", 9, 32'h000000FF);
        wr(9, 32'h0);        rd_chk("R2", 9, 32'h0);

        // R3 config A mask and clear-only bit 0
        wr(1, 32'hFFFFFFFF); rd_chk("R3", 1, 32'hFCFF0101);
        wr(1, 32'h00000001); rd_chk("R3", 1, 32'h00000001);
        wr(1, 32'h00000000); wr(1, 32'h00000001);
        rd_chk("R3", 1, 32'h00000000);

        // R4 selector masks
        for (int s = 0; s < 4; s++) begin
            wr(2 + s, 32'hFFFFFFFF); rd_chk("R4", 2 + s, 32'h0000FFFF);
            wr(2 + s, 32'h0);        rd_chk("R4", 2 + s, 32'h0);
        end

        // R5 set-only lock bits
        wr(7, 32'h00000005); wr(7, 32'h0); rd_chk("R5", 7, 32'h00000005);
        wr(7, 32'h0000000A); rd_chk("R5", 7, 32'h0000000F);

        // R6 flag
        wr(7, 32'h00000100); rd_chk("R6", 7, 32'h0000000F);
        @(negedge clk); parity_evt = 1'b1; @(negedge clk); parity_evt = 1'b0;
        rd_chk("R6", 7, 32'h0000010F);
        wr(7, 32'h0);        rd_chk("R6", 7, 32'h0000010F);
        wr(7, 32'h00000100); rd_chk("R6", 7, 32'h0000000F);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'd28; bus_wdata = 32'h100; parity_evt = 1'b1;
        @(negedge clk); bus_wr = 1'b0; parity_evt = 1'b0;
        rd_chk("R6", 7, 32'h0000010F);

        // R7 sticky protect registers
        wr(8, 32'hA5A5A5A5); wr(8, 32'h0); rd_chk("R7", 8, 32'hA5A5A5A5);
        wr(8, 32'h5A5A5A5A); rd_chk("R7", 8, 32'hFFFFFFFF);
        wr(10, 32'hFFFFFFFF); wr(10, 32'h0); rd_chk("R7", 10, 32'hFFFFFFFF);

        // R11 control/status
        wr(6, 32'hFFFFFFFF); rd_chk("R11", 6, 32'h0);

        // R8 unmapped
        wr(9, 32'h0000003C);
        wr(11, 32'hFFFFFFFF); rd_chk("R8", 11, 32'h0);
        wr(63, 32'hFFFFFFFF); rd_chk("R8", 63, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h25; bus_wdata = 32'hFF;
        @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h25; #1;
        chk("R8", bus_rdata, 32'h0);
        rd_chk("R8", 9, 32'h0000003C);
        rd_chk("R8", 0, 32'h0);

        // Reset restores sticky and clear-only bits (R3, R5, R7)
        do_reset();
        rd_chk("R3", 1, 32'h7C000001);
        rd_chk("R5", 7, 32'h0);
        rd_chk("R7", 8, 32'h0);
        rd_chk("R7", 10, 32'h0);

        // R9 directed: line 0 from port A, port B ignored
        @(negedge clk); gpio_lvl = '0; gpio_lvl[0] = 1'b1;
        #1; chk("R9", {31'h0, irq_line[0]}, 32'h1);
        chk("R9", {16'h0, irq_line}, 32'h1);
        @(negedge clk); gpio_lvl = '0; gpio_lvl[16] = 1'b1;
        #1; chk("R9", {16'h0, irq_line}, 32'h0);
        wr(2, 32'h00000001); sel_model[0] = 16'h0001;
        @(negedge clk); gpio_lvl = '0; gpio_lvl[0] = 1'b1;
        #1; chk("R9", {16'h0, irq_line}, 32'h0);
        @(negedge clk); gpio_lvl = '0; gpio_lvl[16] = 1'b1;
        #1; chk("R9", {16'h0, irq_line}, 32'h1);
        @(negedge clk); gpio_lvl = '0; gpio_lvl[2] = 1'b1;
        #1; chk("R9", {16'h0, irq_line}, 32'h4);
        @(negedge clk); gpio_lvl = '0; gpio_lvl[15] = 1'b1;
        #1; chk("R9", {16'h0, irq_line}, 32'h8000);

        // R10 directed: selector 8 and 15
        wr(2, 32'h0000000F); sel_model[0] = 16'h000F;
        @(negedge clk); gpio_lvl = '1;
        #1; chk("R10", {31'h0, irq_line[0]}, 32'h0);
        wr(5, 32'h8000); sel_model[3] = 16'h8000;
        @(negedge clk); line_chk("R10");

        // R9/R10 random
        for (int it = 0; it < 300; it++) begin
            if (it % 10 == 0) begin
                for (int s = 0; s < 4; s++) begin
                    logic [31:0] d;
                    d = $urandom;
                    wr(2 + s, d);
                    sel_model[s] = d[15:0];
                end
            end
            @(negedge clk);
            gpio_lvl = {$urandom, $urandom, $urandom, $urandom};
            line_chk("R9");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule